// File: doc/BRIEF.md
# Video Memory Write Queue

This block buffers writes from a CPU data port and retires them into three small video memories: a byte-wide video RAM, a colour table and a scroll table. Each queued entry records a byte address, a 16-bit value, a target selector and a half-done marker. Each external access slot (a one-cycle `slot` pulse) retires at most one memory operation. When the video RAM runs in word mode, an entry is written as a whole word in one slot. In byte mode the word is split into two ordered byte writes on two slots, and the entry stays at the head of the queue between them.

The block also supports a fill transfer. While a fill runs and the queue is empty, each slot writes the most recently queued entry again, at the address given on `fill_addr`. The queue itself is a four-entry ring with power-of-two pointer wrap. The CPU side sees `cpu_ready` low while the ring is full.

The control core is a queue state machine with three states: EMPTY, PEND (holding one to three entries) and FULL. Its transitions are EMPTY→PEND on a push, PEND→FULL when a push makes the write pointer reach the read pointer, PEND→EMPTY when a retire makes the read pointer reach the write pointer, and FULL→PEND on any retire. A second machine tracks the transfer state. It has two states, IDLE and RUN, with IDLE→RUN on a non-fill start or on a fill drain, and RUN→IDLE on a stop or on a fill-mode data write.

Top module: `vram_wr_fifo`

## Requirements
- R1: After reset the queue is empty, `cpu_ready` is 1 and `dma_run` is 0.
- R2: `dma_mode` 2'b10 selects fill and 2'b11 selects copy; any other value is a plain transfer. A `ctl_dma_go` pulse starts a run only when the mode is not fill.
- R3: When both `vram_wide` and `mode5` are 1, a video RAM entry (target 0) is retired in one slot. The high byte goes to the address with bit 0 cleared and the low byte to the address with bit 0 set.
- R4: Otherwise, the first slot for a video RAM entry writes its low byte to address XOR 1, and the entry stays queued.
- R5: The following slot writes the high byte of that entry to its original address and retires the entry.
- R6: The ring holds 4 entries. `cpu_ready` is 0 while 4 are pending and returns to 1 after one retire. Entries retire in push order.
- R7: A colour table entry (target 1) writes its whole value to word index address[6:1] in one slot.
- R8: A scroll table entry (target 2) writes word (address/2) mod 64 in one slot.
- R9: While a fill runs with the queue empty, each slot re-issues the last queued entry at `fill_addr` as a half-done entry. In byte mode it writes that entry's high byte to `fill_addr` XOR 1; in word mode it writes the whole word.
- R10: A re-issued colour or scroll entry takes its value from the ring slot at the write pointer, which holds the entry pushed four writes earlier.
- R11: When the queue drains empty while `cmd_dma` is 1 and fill is selected, `dma_run` becomes 1.
- R12: A data write while a non-fill run is active raises `cpu_rej` and queues nothing.
- R13: An accepted data write with `cmd_dma` 1 in fill mode clears `dma_run`.
- R14: A slot with an empty queue and no fill in progress writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_wr | input | 1 | Data port write strobe |
| cpu_addr | input | 16 | Byte address of the write |
| cpu_data | input | 16 | Write value |
| cpu_tgt | input | 2 | Target: 0 video RAM, 1 colour, 2 scroll |
| cpu_ready | output | 1 | Ring can take a write |
| cpu_rej | output | 1 | Current write is refused (non-fill run active) |
| cmd_dma | input | 1 | Command transfer bit |
| dma_mode | input | 2 | Transfer mode field |
| ctl_dma_go | input | 1 | Start pulse for copy or plain transfer |
| dma_stop | input | 1 | Ends the current run |
| vram_wide | input | 1 | Large video RAM select |
| mode5 | input | 1 | Extended display mode select |
| slot | input | 1 | External access slot pulse |
| fill_addr | input | 16 | Current address for fill writes |
| dma_run | output | 1 | Transfer run flag |
| fifo_empty | output | 1 | Ring holds no entries |
| rd_tgt | input | 2 | Memory read select for display fetch |
| rd_addr | input | 16 | Read byte address |
| rd_data | output | 16 | Read data (video RAM byte zero-extended) |

## Verification
Byte-mode writes are swept over even and odd addresses, so that a swapped byte lane or a missing XOR shows up in the bytes read back after each of the two slots. Word-mode writes use the same addresses, once with `mode5` low to show that both select bits are needed. Pushes to a repeated colour index tell ordered from unordered retirement, and the full-ring case checks the ready stall. Fill runs are tried in byte and word mode and on a colour entry, which separates the last-written entry from the entry at the write pointer.

// File: rtl/vmf_pkg.sv
package vmf_pkg;
    localparam int ENT_AW = 16;

    typedef enum logic [1:0] {
        TG_VRAM  = 2'd0,
        TG_CRAM  = 2'd1,
        TG_VSRAM = 2'd2
    } tgt_e;

    localparam logic [1:0] MODE_FILL = 2'b10;
    localparam logic [1:0] MODE_COPY = 2'b11;

    typedef struct packed {
        logic [ENT_AW-1:0] addr;
        logic [15:0]       val;
        tgt_e              tgt;
        logic              part;
    } entry_t;

    typedef enum logic [1:0] {
        FS_EMPTY = 2'd0,
        FS_PEND  = 2'd1,
        FS_FULL  = 2'd2
    } fstate_e;

    typedef enum logic {
        DS_IDLE = 1'b0,
        DS_RUN  = 1'b1
    } dstate_e;
endpackage

// File: rtl/vmf_queue.sv
module vmf_queue
    import vmf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  entry_t               push_ent,
    input  logic                 pop,
    input  logic                 upd,
    input  logic [ENT_AW-1:0]    upd_addr,
    output entry_t               head,
    output entry_t               last,
    output entry_t               wrp,
    output logic                 empty,
    output logic                 full,
    output logic                 going_empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    entry_t          mem [DEPTH];
    logic [PW-1:0]   rd_ptr, wr_ptr;
    fstate_e         state, nxt;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_ent;
        if (upd) begin
            mem[rd_ptr].addr <= upd_addr;
            mem[rd_ptr].part <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= FS_EMPTY;
            rd_ptr <= '0;
            wr_ptr <= '0;
        end else begin
            state <= nxt;
            if (push) wr_ptr <= wr_ptr + PW'(1);
            if (pop)  rd_ptr <= rd_ptr + PW'(1);
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            FS_EMPTY: if (push) nxt = FS_PEND;
            FS_PEND: begin
                if (push && !pop && (wr_ptr + PW'(1) == rd_ptr))
                    nxt = FS_FULL;
                else if (pop && !push && (rd_ptr + PW'(1) == wr_ptr))
                    nxt = FS_EMPTY;
            end
            FS_FULL: if (pop) nxt = FS_PEND;
            default: nxt = FS_EMPTY;
        endcase
    end

    always_comb begin
        head        = mem[rd_ptr];
        last        = mem[wr_ptr - PW'(1)];
        wrp         = mem[wr_ptr];
        empty       = (state == FS_EMPTY);
        full        = (state == FS_FULL);
        going_empty = (state != FS_EMPTY) && (nxt == FS_EMPTY);
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (state != FS_FULL));

    // R14
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (state != FS_EMPTY));

    // R4
    split_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !pop) |=> (rd_ptr == $past(rd_ptr)) && mem[rd_ptr].part);

    // R6
    full_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_FULL) |-> (wr_ptr == rd_ptr));
endmodule

// File: rtl/vmf_drain.sv
module vmf_drain
    import vmf_pkg::*;
#(
    parameter int CS_AW = 6
) (
    input  logic                slot,
    input  logic                empty,
    input  logic                fill_on,
    input  logic                wide,
    input  logic [ENT_AW-1:0]   fill_addr,
    input  entry_t              head,
    input  entry_t              last,
    input  entry_t              wrp,
    output logic                pop,
    output logic                upd,
    output logic [ENT_AW-1:0]   upd_addr,
    output logic                vb0_we,
    output logic [ENT_AW-1:0]   vb0_addr,
    output logic [7:0]          vb0_data,
    output logic                vb1_we,
    output logic [ENT_AW-1:0]   vb1_addr,
    output logic [7:0]          vb1_data,
    output logic                cr_we,
    output logic                vs_we,
    output logic [CS_AW-1:0]    cs_idx,
    output logic [15:0]         cs_data
);
    localparam logic [ENT_AW-1:0] BIT0 = ENT_AW'(1);

    entry_t src;
    logic   retire;

    always_comb begin
        src      = head;
        if (empty) begin
            src.addr = fill_addr;
            src.val  = last.val;
            src.tgt  = last.tgt;
            src.part = 1'b1;
        end
        retire   = 1'b0;
        upd      = 1'b0;
        upd_addr = src.addr ^ BIT0;
        vb0_we   = 1'b0;
        vb0_addr = src.addr ^ BIT0;
        vb0_data = src.part ? src.val[15:8] : src.val[7:0];
        vb1_we   = 1'b0;
        vb1_addr = src.addr | BIT0;
        vb1_data = src.val[7:0];
        cr_we    = 1'b0;
        vs_we    = 1'b0;
        cs_idx   = src.addr[CS_AW:1];
        cs_data  = src.part ? wrp.val : src.val;
        if (slot && (!empty || fill_on)) begin
            case (src.tgt)
                TG_VRAM: begin
                    vb0_we = 1'b1;
                    if (wide) begin
                        vb0_addr = src.addr & ~BIT0;
                        vb0_data = src.val[15:8];
                        vb1_we   = 1'b1;
                        retire   = 1'b1;
                    end else if (src.part) begin
                        retire = 1'b1;
                    end else begin
                        upd = 1'b1;
                    end
                end
                TG_CRAM: begin
                    cr_we  = 1'b1;
                    retire = 1'b1;
                end
                TG_VSRAM: begin
                    vs_we  = 1'b1;
                    retire = 1'b1;
                end
                default: retire = 1'b1;
            endcase
        end
        pop = retire && !empty;
    end
endmodule

// File: rtl/vmf_mems.sv
module vmf_mems
    import vmf_pkg::*;
#(
    parameter int VRAM_AW = 10,
    parameter int CS_AW   = 6
) (
    input  logic                clk,
    input  logic                vb0_we,
    input  logic [ENT_AW-1:0]   vb0_addr,
    input  logic [7:0]          vb0_data,
    input  logic                vb1_we,
    input  logic [ENT_AW-1:0]   vb1_addr,
    input  logic [7:0]          vb1_data,
    input  logic                cr_we,
    input  logic                vs_we,
    input  logic [CS_AW-1:0]    cs_idx,
    input  logic [15:0]         cs_data,
    input  logic [1:0]          rd_tgt,
    input  logic [ENT_AW-1:0]   rd_addr,
    output logic [15:0]         rd_data
);
    localparam int VDEPTH = 1 << VRAM_AW;
    localparam int CDEPTH = 1 << CS_AW;

    logic [7:0]  vram  [VDEPTH];
    logic [15:0] cram  [CDEPTH];
    logic [15:0] vsram [CDEPTH];

    always_ff @(posedge clk) begin
        if (vb0_we) vram[vb0_addr[VRAM_AW-1:0]] <= vb0_data;
        if (vb1_we) vram[vb1_addr[VRAM_AW-1:0]] <= vb1_data;
        if (cr_we)  cram[cs_idx]  <= cs_data;
        if (vs_we)  vsram[cs_idx] <= cs_data;
    end

    always_comb begin
        case (rd_tgt)
            2'd0:    rd_data = {8'h00, vram[rd_addr[VRAM_AW-1:0]]};
            2'd1:    rd_data = cram[rd_addr[CS_AW:1]];
            2'd2:    rd_data = vsram[rd_addr[CS_AW:1]];
            default: rd_data = 16'h0000;
        endcase
    end
endmodule

// File: rtl/vram_wr_fifo.sv
module vram_wr_fifo
    import vmf_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int VRAM_AW = 10,
    parameter int CS_AW   = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cpu_wr,
    input  logic [15:0]  cpu_addr,
    input  logic [15:0]  cpu_data,
    input  logic [1:0]   cpu_tgt,
    output logic         cpu_ready,
    output logic         cpu_rej,
    input  logic         cmd_dma,
    input  logic [1:0]   dma_mode,
    input  logic         ctl_dma_go,
    input  logic         dma_stop,
    input  logic         vram_wide,
    input  logic         mode5,
    input  logic         slot,
    input  logic [15:0]  fill_addr,
    output logic         dma_run,
    output logic         fifo_empty,
    input  logic [1:0]   rd_tgt,
    input  logic [15:0]  rd_addr,
    output logic [15:0]  rd_data
);
    dstate_e             dstate, dnxt;
    logic                is_fill, accept, fill_on, wide;
    logic                pop, upd, empty, full, going_empty;
    logic [ENT_AW-1:0]   upd_addr;
    entry_t              push_ent, head, last, wrp;
    logic                vb0_we, vb1_we, cr_we, vs_we;
    logic [ENT_AW-1:0]   vb0_addr, vb1_addr;
    logic [7:0]          vb0_data, vb1_data;
    logic [CS_AW-1:0]    cs_idx;
    logic [15:0]         cs_data;

    always_comb begin
        is_fill   = (dma_mode == MODE_FILL);
        wide      = vram_wide && mode5;
        dma_run   = (dstate == DS_RUN);
        fill_on   = dma_run && is_fill;
        cpu_rej   = cpu_wr && dma_run && !is_fill;
        cpu_ready = !full;
        accept    = cpu_wr && !cpu_rej && !full;
        fifo_empty = empty;
        push_ent.addr = cpu_addr;
        push_ent.val  = cpu_data;
        push_ent.tgt  = tgt_e'(cpu_tgt);
        push_ent.part = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dstate <= DS_IDLE;
        else        dstate <= dnxt;
    end

    always_comb begin
        dnxt = dstate;
        unique case (dstate)
            DS_IDLE: begin
                if (!dma_stop && ((ctl_dma_go && !is_fill) ||
                                  (going_empty && cmd_dma && is_fill)))
                    dnxt = DS_RUN;
            end
            DS_RUN: begin
                if (dma_stop || (accept && cmd_dma && is_fill))
                    dnxt = DS_IDLE;
            end
            default: dnxt = DS_IDLE;
        endcase
    end

    vmf_queue #(.DEPTH(DEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(accept), .push_ent(push_ent),
        .pop(pop), .upd(upd), .upd_addr(upd_addr), .head(head),
        .last(last), .wrp(wrp), .empty(empty), .full(full),
        .going_empty(going_empty)
    );

    vmf_drain #(.CS_AW(CS_AW)) u_drain (
        .slot(slot), .empty(empty), .fill_on(fill_on), .wide(wide),
        .fill_addr(fill_addr), .head(head), .last(last), .wrp(wrp),
        .pop(pop), .upd(upd), .upd_addr(upd_addr),
        .vb0_we(vb0_we), .vb0_addr(vb0_addr), .vb0_data(vb0_data),
        .vb1_we(vb1_we), .vb1_addr(vb1_addr), .vb1_data(vb1_data),
        .cr_we(cr_we), .vs_we(vs_we), .cs_idx(cs_idx), .cs_data(cs_data)
    );

    vmf_mems #(.VRAM_AW(VRAM_AW), .CS_AW(CS_AW)) u_mems (
        .clk(clk), .vb0_we(vb0_we), .vb0_addr(vb0_addr), .vb0_data(vb0_data),
        .vb1_we(vb1_we), .vb1_addr(vb1_addr), .vb1_data(vb1_data),
        .cr_we(cr_we), .vs_we(vs_we), .cs_idx(cs_idx), .cs_data(cs_data),
        .rd_tgt(rd_tgt), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // R12
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rej && empty) |=> empty);

    // R11
    run_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_run) |-> $past(ctl_dma_go || going_empty));

    // R14
    idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !fill_on) |-> !(vb0_we || vb1_we || cr_we || vs_we));

    // R13
    fill_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_dma && is_fill && !dma_stop) |=> !dma_run);
endmodule

// File: tb/vram_wr_fifo_tb.sv
module vram_wr_fifo_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = '0, cpu_data = '0, fill_addr = '0, rd_addr = '0;
    logic [1:0]  cpu_tgt = '0, dma_mode = '0, rd_tgt = '0;
    logic        cmd_dma = 1'b0, ctl_dma_go = 1'b0, dma_stop = 1'b0;
    logic        vram_wide = 1'b0, mode5 = 1'b0, slot = 1'b0;
    logic        cpu_ready, cpu_rej, dma_run, fifo_empty;
    logic [15:0] rd_data;

    int n_tests = 0, n_fail = 0;
    logic [15:0] sh_val [4];
    int wi = 0;
    bit done = 0;

    always #4 clk = ~clk;

    vram_wr_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_data(cpu_data), .cpu_tgt(cpu_tgt), .cpu_ready(cpu_ready),
        .cpu_rej(cpu_rej), .cmd_dma(cmd_dma), .dma_mode(dma_mode),
        .ctl_dma_go(ctl_dma_go), .dma_stop(dma_stop), .vram_wide(vram_wide),
        .mode5(mode5), .slot(slot), .fill_addr(fill_addr), .dma_run(dma_run),
        .fifo_empty(fifo_empty), .rd_tgt(rd_tgt), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic push(input logic [1:0] t, input logic [15:0] a, input logic [15:0] v);
        cpu_wr = 1'b1; cpu_tgt = t; cpu_addr = a; cpu_data = v;
        @(posedge clk); #1;
        cpu_wr = 1'b0;
        sh_val[wi] = v;
        wi = (wi + 1) % 4;
    endtask

    task automatic tick_slot();
        slot = 1'b1;
        @(posedge clk); #1;
        slot = 1'b0;
    endtask

    task automatic pulse_go();
        ctl_dma_go = 1'b1;
        @(posedge clk); #1;
        ctl_dma_go = 1'b0;
    endtask

    task automatic pulse_stop();
        dma_stop = 1'b1;
        @(posedge clk); #1;
        dma_stop = 1'b0;
    endtask

    task automatic peek(input logic [1:0] t, input logic [15:0] a, output logic [15:0] d);
        rd_tgt = t; rd_addr = a; #1;
        d = rd_data;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] d, v;
        logic [15:0] addrs [6];
        addrs = '{16'd16, 16'd17, 16'd42, 16'd43, 16'd510, 16'd1023};
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        check("R1 empty", 16'(fifo_empty), 16'd1);
        check("R1 ready", 16'(cpu_ready), 16'd1);
        check("R1 run", 16'(dma_run), 16'd0);

        // R4/R5 byte mode sweep over even and odd addresses
        for (int i = 0; i < 6; i++) begin
            v = 16'h1234 + 16'(i) * 16'h1111;
            push(2'd0, addrs[i], v);
            tick_slot();
            peek(2'd0, addrs[i] ^ 16'd1, d);
            check("R4 low byte", d, {8'h00, v[7:0]});
            check("R4 still queued", 16'(fifo_empty), 16'd0);
            tick_slot();
            peek(2'd0, addrs[i], d);
            check("R5 high byte", d, {8'h00, v[15:8]});
            check("R5 retired", 16'(fifo_empty), 16'd1);
        end

        // R3 word mode
        vram_wide = 1'b1; mode5 = 1'b1;
        for (int i = 0; i < 6; i++) begin
            v = 16'hA05F ^ (16'(i) << 4);
            push(2'd0, addrs[i], v);
            tick_slot();
            peek(2'd0, addrs[i] & 16'hFFFE, d);
            check("R3 high even", d, {8'h00, v[15:8]});
            peek(2'd0, addrs[i] | 16'd1, d);
            check("R3 low odd", d, {8'h00, v[7:0]});
            check("R3 one slot", 16'(fifo_empty), 16'd1);
        end
        // R3 needs both selects: mode5 low behaves as byte mode
        mode5 = 1'b0;
        push(2'd0, 16'd100, 16'h7788);
        tick_slot();
        check("R3 partial select queued", 16'(fifo_empty), 16'd0);
        tick_slot();
        peek(2'd0, 16'd100, d);
        check("R3 partial select high", d, 16'h0077);
        vram_wide = 1'b0;

        // R6 depth and order, R7 colour index
        for (int k = 0; k < 4; k++) push(2'd1, 16'(2 * k), 16'h1111 * 16'(k + 1));
        check("R6 full stalls", 16'(cpu_ready), 16'd0);
        tick_slot();
        check("R6 ready after retire", 16'(cpu_ready), 16'd1);
        push(2'd1, 16'd0, 16'h5555);
        for (int k = 0; k < 4; k++) tick_slot();
        check("R6 drained", 16'(fifo_empty), 16'd1);
        for (int k = 1; k < 4; k++) begin
            peek(2'd1, 16'(2 * k), d);
            check("R7 colour word", d, 16'h1111 * 16'(k + 1));
        end
        peek(2'd1, 16'd0, d);
        check("R6 order last wins", d, 16'h5555);

        // R8 scroll index wraps at 64 words
        push(2'd2, 16'd140, 16'hBEEF);
        tick_slot();
        peek(2'd2, 16'd12, d);
        check("R8 scroll wrap", d, 16'hBEEF);

        // R2/R12 copy run rejects writes
        dma_mode = 2'b11;
        pulse_go();
        check("R2 copy starts run", 16'(dma_run), 16'd1);
        cpu_wr = 1'b1; cpu_tgt = 2'd0; cpu_addr = 16'd60; cpu_data = 16'h9999;
        #1 check("R12 reject flag", 16'(cpu_rej), 16'd1);
        @(posedge clk); #1 cpu_wr = 1'b0;
        check("R12 nothing queued", 16'(fifo_empty), 16'd1);
        pulse_stop();
        check("R2 stop", 16'(dma_run), 16'd0);
        dma_mode = 2'b10;
        pulse_go();
        check("R2 fill not started by go", 16'(dma_run), 16'd0);

        // R11/R9 fill in byte mode
        cmd_dma = 1'b1;
        push(2'd0, 16'd40, 16'hC3A5);
        check("R13 run low after fill write", 16'(dma_run), 16'd0);
        tick_slot();
        tick_slot();
        check("R11 drain sets run", 16'(dma_run), 16'd1);
        fill_addr = 16'd100;
        tick_slot();
        peek(2'd0, 16'd101, d);
        check("R9 fill byte even", d, 16'h00C3);
        fill_addr = 16'd201;
        tick_slot();
        peek(2'd0, 16'd200, d);
        check("R9 fill byte odd", d, 16'h00C3);
        vram_wide = 1'b1; mode5 = 1'b1;
        fill_addr = 16'd301;
        tick_slot();
        peek(2'd0, 16'd300, d);
        check("R9 fill word high", d, 16'h00C3);
        peek(2'd0, 16'd301, d);
        check("R9 fill word low", d, 16'h00A5);
        // R13 a fill-mode write stops the run
        push(2'd0, 16'd50, 16'h1E2D);
        check("R13 write clears run", 16'(dma_run), 16'd0);
        tick_slot();
        check("R11 run again after drain", 16'(dma_run), 16'd1);
        pulse_stop();
        vram_wide = 1'b0; mode5 = 1'b0;

        // R10 fill with a colour entry uses the ring slot at write pointer
        push(2'd1, 16'd2, 16'h0ACE);
        tick_slot();
        check("R11 colour drain sets run", 16'(dma_run), 16'd1);
        fill_addr = 16'd8;
        tick_slot();
        peek(2'd1, 16'd8, d);
        check("R10 colour fill value", d, sh_val[wi]);
        pulse_stop();
        cmd_dma = 1'b0; dma_mode = 2'b00;

        // R14 idle slot writes nothing
        peek(2'd0, 16'd300, d);
        tick_slot();
        peek(2'd0, 16'd300, v);
        check("R14 idle slot", v, d);
        check("R14 still empty", 16'(fifo_empty), 16'd1);

        finish_run();
    end
endmodule